// File: doc/BRIEF.md
# Serial Receiver with Error Status

This block receives asynchronous serial frames on a single line and hands each byte to a register reader. An input pulse `baud_tick` runs at sixteen times the bit rate. The line is passed through a short synchronizer. A falling edge starts a frame, and the start bit is confirmed by a low sample at its middle. The receiver then takes the data bits least significant first, one optional parity bit, and the stop bit or bits. Each of these is sampled at the middle of its bit time.

When a frame completes, the byte goes into a one-entry receive buffer and `data_ready` is raised. If the buffer still holds a byte that nobody has read, the new byte is dropped and an overrun is recorded. Parity, framing and overrun errors are collected in an 8-bit status register that is read-only.

A register reader selects the status register or the buffer with `rd_addr` and pulses `rd_en`. `rd_data` shows the selected register in the same cycle. The read's side effect takes hold at the next clock edge. The intended handling of an error is to read the status register first and then the buffer. Dropping either of the two enables puts the receiver in its idle state and wipes the error flags.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset the status register reads 00h, the buffer reads 00h and `data_ready` is 0.
- R2: A frame is a low start bit, then 8 data bits least significant first, then an optional parity bit, then the stop bit(s). When it completes with the buffer empty, the byte is stored in the buffer and `data_ready` goes to 1. A frame with no error leaves the status register at 00h.
- R3: `par_sel` selects the parity mode. 00 means no parity bit is expected. 01 means a parity bit is present but never checked. 10 means odd parity, where the data bits plus the parity bit hold an odd number of ones. 11 means even parity. In modes 10 and 11 a mismatch sets status bit 2.
- R4: If the first stop bit is sampled low, status bit 1 is set. The byte is still stored.
- R5: With `two_stop`=1 only the first stop bit is checked. A low second stop bit sets no flag.
- R6: If a frame completes while `data_ready` is 1, status bit 0 is set and the new byte is dropped. The buffer keeps the earlier byte.
- R7: A status read (`rd_en`=1, `rd_addr`=0) clears bits 2..0 at the next clock edge. Bits 7..3 always read 0.
- R8: A buffer read (`rd_en`=1, `rd_addr`=1) returns the stored byte and clears `data_ready`.
- R9: While `pwr_en` or `rx_en` is 0, the error flags and `data_ready` are held at 0 and no frame is received.
- R10: If a frame that sets an error flag completes in the same cycle as a status read, the flag is set.
- R11: A low pulse on the line that ends before the middle of the start bit starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| pwr_en | input | 1 | Unit power enable |
| rx_en | input | 1 | Reception enable |
| par_sel | input | 2 | Parity mode (see R3) |
| two_stop | input | 1 | Two stop bits per frame |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | 1 | 0 selects status, 1 selects buffer |
| rd_data | output | 8 | Selected register contents |
| data_ready | output | 1 | Buffer holds an unread byte |

## Verification
A frame's result reaches the status register and `data_ready` two clocks after the tick that samples the first stop bit. One clock is spent in the frame sequencer and one in the status register. The line also passes through two synchronizer flops before it is sampled.

The exact completion cycle is not predicted. The behavioural model takes each frame's outcome only after the line has been idle for two full bit times following the stop bits. From then on it is compared with the status register and `data_ready` on every clock.

Read data is checked a few time units after the strobe is applied, in the same cycle. The clear caused by a read is expected from the following clock onward. The same-cycle priority case (R10) is checked by holding a status read for the whole frame and watching for the parity flag.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

   localparam int STAT_W  = 8;
   localparam int BIT_OVR = 0;
   localparam int BIT_FRM = 1;
   localparam int BIT_PAR = 2;

   localparam logic [1:0] PSEL_NONE = 2'b00;
   localparam logic [1:0] PSEL_ZERO = 2'b01;
   localparam logic [1:0] PSEL_ODD  = 2'b10;
   localparam logic [1:0] PSEL_EVEN = 2'b11;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_STOP2
   } rx_state_e;

endpackage

// File: rtl/rxu_sync.sv
module rxu_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[gi] <= 1'b1;
            end else begin
               if (gi == 0) begin
                  chain[gi] <= d_in;
               end else begin
                  chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
               end
            end
         end
      end
   endgenerate

   assign d_out = chain[STAGES-1];

endmodule

// File: rtl/rxu_frame.sv
module rxu_frame
   import rxu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              tick,
   input  logic              rx_s,
   input  logic [1:0]        par_sel,
   input  logic              two_stop,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              perr,
   output logic              ferr
);

   localparam int CNT_W = $clog2(OSR);
   localparam int BIT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
   localparam logic [BIT_W-1:0] TOPB = BIT_W'(DATA_W - 1);

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bitn;
   logic [DATA_W-1:0] shreg;
   logic              par_acc;
   logic              prev_hi;
   logic              perr_q;
   logic              ferr_q;
   logic              at_mid;
   logic              at_last;
   logic              par_seen;

   assign at_mid   = (cnt == MID);
   assign at_last  = (cnt == LAST);
   assign par_seen = par_acc ^ rx_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         bitn    <= '0;
         shreg   <= '0;
         par_acc <= 1'b0;
         prev_hi <= 1'b0;
         perr_q  <= 1'b0;
         ferr_q  <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!enable) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            prev_hi <= 1'b0;
         end else if (tick) begin
            prev_hi <= rx_s;
            cnt     <= cnt + 1'b1;
            case (state)
               ST_IDLE: begin
                  cnt <= '0;
                  if (prev_hi && !rx_s) begin
                     state <= ST_START;
                  end
               end
               ST_START: begin
                  if (at_mid) begin
                     cnt     <= '0;
                     bitn    <= '0;
                     par_acc <= 1'b0;
                     perr_q  <= 1'b0;
                     state   <= rx_s ? ST_IDLE : ST_DATA;
                  end
               end
               ST_DATA: begin
                  if (at_last) begin
                     cnt     <= '0;
                     shreg   <= {rx_s, shreg[DATA_W-1:1]};
                     par_acc <= par_acc ^ rx_s;
                     if (bitn == TOPB) begin
                        state <= (par_sel == PSEL_NONE) ? ST_STOP : ST_PAR;
                     end else begin
                        bitn <= bitn + 1'b1;
                     end
                  end
               end
               ST_PAR: begin
                  if (at_last) begin
                     cnt <= '0;
                     case (par_sel)
                        PSEL_ODD:  perr_q <= ~par_seen;
                        PSEL_EVEN: perr_q <= par_seen;
                        default:   perr_q <= 1'b0;
                     endcase
                     state <= ST_STOP;
                  end
               end
               ST_STOP: begin
                  if (at_last) begin
                     cnt    <= '0;
                     done   <= 1'b1;
                     ferr_q <= ~rx_s;
                     state  <= two_stop ? ST_STOP2 : ST_IDLE;
                  end
               end
               ST_STOP2: begin
                  if (at_last) begin
                     cnt   <= '0;
                     state <= ST_IDLE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign data = shreg;
   assign perr = perr_q;
   assign ferr = ferr_q;

endmodule

// File: rtl/rxu_status.sv
module rxu_status
   import rxu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              done,
   input  logic [DATA_W-1:0] data,
   input  logic              perr,
   input  logic              ferr,
   input  logic              rd_stat,
   input  logic              rd_buf,
   output logic [DATA_W-1:0] buf_q,
   output logic              ready_q,
   output logic [STAT_W-1:0] stat
);

   logic ovr_q;
   logic frm_q;
   logic par_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q   <= 1'b0;
         frm_q   <= 1'b0;
         par_q   <= 1'b0;
         ready_q <= 1'b0;
         buf_q   <= '0;
      end else if (!enable) begin
         ovr_q   <= 1'b0;
         frm_q   <= 1'b0;
         par_q   <= 1'b0;
         ready_q <= 1'b0;
      end else begin
         if (rd_stat) begin
            ovr_q <= 1'b0;
            frm_q <= 1'b0;
            par_q <= 1'b0;
         end
         if (rd_buf) begin
            ready_q <= 1'b0;
         end
         if (done) begin
            if (perr) par_q <= 1'b1;
            if (ferr) frm_q <= 1'b1;
            if (ready_q && !rd_buf) begin
               ovr_q <= 1'b1;
            end else begin
               buf_q   <= data;
               ready_q <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      stat          = '0;
      stat[BIT_OVR] = ovr_q;
      stat[BIT_FRM] = frm_q;
      stat[BIT_PAR] = par_q;
   end

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
   import rxu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic       rx_in,
   input  logic       pwr_en,
   input  logic       rx_en,
   input  logic [1:0] par_sel,
   input  logic       two_stop,
   input  logic       rd_en,
   input  logic       rd_addr,
   output logic [7:0] rd_data,
   output logic       data_ready
);

   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("OSR must be even and at least 4");
      end
      if (DATA_W < 5 || DATA_W > STAT_W) begin : g_bad_width
         $error("DATA_W must lie between 5 and 8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              rx_s;
   logic              unit_on;
   logic              frm_done;
   logic [DATA_W-1:0] frm_data;
   logic              frm_perr;
   logic              frm_ferr;
   logic              rd_stat;
   logic              rd_buf;
   logic [DATA_W-1:0] buf_w;
   logic [STAT_W-1:0] stat_w;
   logic [7:0]        buf_ext;

   assign unit_on = pwr_en & rx_en;
   assign rd_stat = rd_en & ~rd_addr;
   assign rd_buf  = rd_en & rd_addr;

   rxu_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rx_in),
      .d_out (rx_s)
   );

   rxu_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (unit_on),
      .tick     (baud_tick),
      .rx_s     (rx_s),
      .par_sel  (par_sel),
      .two_stop (two_stop),
      .done     (frm_done),
      .data     (frm_data),
      .perr     (frm_perr),
      .ferr     (frm_ferr)
   );

   rxu_status #(.DATA_W(DATA_W)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (unit_on),
      .done    (frm_done),
      .data    (frm_data),
      .perr    (frm_perr),
      .ferr    (frm_ferr),
      .rd_stat (rd_stat),
      .rd_buf  (rd_buf),
      .buf_q   (buf_w),
      .ready_q (data_ready),
      .stat    (stat_w)
   );

   generate
      if (DATA_W == 8) begin : g_full
         assign buf_ext = buf_w;
      end else begin : g_pad
         assign buf_ext = {{(8-DATA_W){1'b0}}, buf_w};
      end
   endgenerate

   assign rd_data = rd_addr ? buf_ext : stat_w;

endmodule

// File: rtl/rxu_checker.sv
module rxu_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwr_en,
   input logic              rx_en,
   input logic              rd_en,
   input logic              rd_addr,
   input logic              data_ready,
   input logic              frm_done,
   input logic              frm_perr,
   input logic [7:0]        stat,
   input logic [DATA_W-1:0] buf_q
);

   logic on;
   assign on = pwr_en & rx_en;

   assert_done_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && on |=> data_ready);

   assert_flag_from_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[1]) |-> $past(frm_done));

   assert_overrun_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && on && data_ready && !(rd_en && rd_addr) |=> stat[0] && $stable(buf_q));

   assert_stat_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !rd_addr && !frm_done |=> stat[2:0] == 3'b000);

   assert_buf_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && rd_addr && !frm_done |=> !data_ready);

   assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !on |=> stat == 8'h00 && !data_ready);

   assert_error_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && frm_perr && on |=> stat[2]);

endmodule

bind serial_rx_unit rxu_checker #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_en     (pwr_en),
   .rx_en      (rx_en),
   .rd_en      (rd_en),
   .rd_addr    (rd_addr),
   .data_ready (data_ready),
   .frm_done   (frm_done),
   .frm_perr   (frm_perr),
   .stat       (stat_w),
   .buf_q      (buf_w)
);

// File: tb/serial_rx_unit_test.sv
module serial_rx_unit_test;

   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int BIT_CLKS   = 16 * TICK_DIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       rx_in = 1'b1;
   logic       pwr_en = 1'b1;
   logic       rx_en = 1'b1;
   logic [1:0] par_sel = 2'b00;
   logic       two_stop = 1'b0;
   logic       rd_en = 1'b0;
   logic       rd_addr = 1'b0;
   logic [7:0] rd_data;
   logic       data_ready;

   int n_checks = 0;
   int n_fail   = 0;

   // behavioural model
   bit       m_ovr = 0, m_frm = 0, m_par = 0, m_ready = 0;
   bit [7:0] m_buf = 8'h00;
   bit       settled = 0;
   bit       busy = 0;
   bit       seen_par = 0;

   serial_rx_unit uut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_in(rx_in),
      .pwr_en(pwr_en), .rx_en(rx_en), .par_sel(par_sel), .two_stop(two_stop),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .data_ready(data_ready)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      forever begin
         repeat (TICK_DIV - 1) @(negedge clk);
         baud_tick = 1'b1;
         @(negedge clk);
         baud_tick = 1'b0;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit [7:0] m_stat();
      return {5'b00000, m_par, m_frm, m_ovr};
   endfunction

   // per-clock comparison against the model while no frame is in flight
   always begin
      @(negedge clk);
      #2;
      if (rst_n && settled && !busy) begin
         check(rd_data == m_stat(), "R2 R6 R7 model status", rd_data, m_stat());
         check(data_ready == m_ready, "R2 R8 model data_ready", data_ready, m_ready);
      end
   end

   always begin
      @(negedge clk);
      #3;
      if (rd_en && !rd_addr && rd_data[2]) seen_par = 1;
   end

   task automatic line_bit(input bit v);
      rx_in = v;
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   task automatic send_frame(input bit [7:0] d, input bit bad_par,
                             input bit stop1, input bit stop2);
      bit p;
      settled = 0;
      case (par_sel)
         2'b10:   p = ~(^d);
         2'b11:   p = ^d;
         default: p = 1'b0;
      endcase
      if (bad_par) p = ~p;
      line_bit(1'b0);
      for (int i = 0; i < 8; i++) line_bit(d[i]);
      if (par_sel != 2'b00) line_bit(p);
      line_bit(stop1);
      if (two_stop) line_bit(stop2);
      line_bit(1'b1);
      line_bit(1'b1);
      if (bad_par && par_sel[1]) m_par = 1;
      if (!stop1) m_frm = 1;
      if (m_ready) begin
         m_ovr = 1;
      end else begin
         m_buf   = d;
         m_ready = 1;
      end
      settled = 1;
   endtask

   task automatic read_reg(input bit addr, input bit [7:0] exp, input string tag);
      busy    = 1;
      rd_en   = 1'b1;
      rd_addr = addr;
      #2;
      check(rd_data == exp, tag, rd_data, exp);
      @(negedge clk);
      rd_en   = 1'b0;
      rd_addr = 1'b0;
      if (addr) m_ready = 0;
      else begin m_ovr = 0; m_frm = 0; m_par = 0; end
      busy = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R2: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1 reset state
      check(data_ready == 1'b0, "R1 data_ready after reset", data_ready, 0);
      read_reg(1'b0, 8'h00, "R1 status after reset");
      read_reg(1'b1, 8'h00, "R1 buffer after reset");
      settled = 1;

      // R2 plain frame, no parity
      send_frame(8'hA5, 0, 1, 1);
      check(data_ready == 1'b1, "R2 data_ready after frame", data_ready, 1);
      read_reg(1'b0, 8'h00, "R2 status clean frame");
      read_reg(1'b1, 8'hA5, "R2 buffer byte lsb first");
      check(data_ready == 1'b0, "R8 data_ready after buffer read", data_ready, 0);

      // R3 odd parity, good then bad
      par_sel = 2'b10;
      send_frame(8'h3C, 0, 1, 1);
      read_reg(1'b0, 8'h00, "R3 odd parity good");
      read_reg(1'b1, 8'h3C, "R3 odd buffer");
      send_frame(8'h3D, 1, 1, 1);
      read_reg(1'b0, 8'h04, "R3 odd parity bad");
      read_reg(1'b1, 8'h3D, "R3 odd bad buffer");
      // R3 even parity bad
      par_sel = 2'b11;
      send_frame(8'h81, 1, 1, 1);
      read_reg(1'b0, 8'h04, "R3 even parity bad");
      read_reg(1'b1, 8'h81, "R3 even bad buffer");
      // R3 forced zero parity bit, not checked
      par_sel = 2'b01;
      send_frame(8'h7E, 1, 1, 1);
      read_reg(1'b0, 8'h00, "R3 zero mode unchecked");
      read_reg(1'b1, 8'h7E, "R3 zero mode buffer");

      // R4 framing error
      par_sel = 2'b00;
      send_frame(8'h5A, 0, 0, 1);
      read_reg(1'b0, 8'h02, "R4 framing flag");
      read_reg(1'b1, 8'h5A, "R4 byte stored despite framing");

      // R5 second stop low is ignored
      two_stop = 1'b1;
      send_frame(8'hC3, 0, 1, 0);
      read_reg(1'b0, 8'h00, "R5 second stop unchecked");
      read_reg(1'b1, 8'hC3, "R5 buffer");
      two_stop = 1'b0;

      // R6 overrun: two frames, no read between
      send_frame(8'h11, 0, 1, 1);
      send_frame(8'h22, 0, 1, 1);
      read_reg(1'b0, 8'h01, "R6 overrun flag");
      read_reg(1'b1, 8'h11, "R6 old byte kept");
      read_reg(1'b0, 8'h00, "R7 status cleared by read");

      // R9 disable clears flags and data_ready
      send_frame(8'h66, 0, 0, 1);
      check(data_ready == 1'b1, "R9 ready before disable", data_ready, 1);
      busy = 1;
      rx_en = 1'b0;
      repeat (3) @(negedge clk);
      #2;
      check(rd_data == 8'h00, "R9 status while disabled", rd_data, 0);
      check(data_ready == 1'b0, "R9 data_ready while disabled", data_ready, 0);
      rx_en = 1'b1;
      m_ovr = 0; m_frm = 0; m_par = 0; m_ready = 0;
      @(negedge clk);
      busy = 0;
      repeat (2) @(negedge clk);
      read_reg(1'b0, 8'h00, "R9 status after re-enable");

      // R11 short low glitch is not a start bit
      settled = 0;
      rx_in = 1'b0;
      repeat (4 * TICK_DIV) @(negedge clk);
      rx_in = 1'b1;
      repeat (3 * BIT_CLKS) @(negedge clk);
      settled = 1;
      #2;
      check(data_ready == 1'b0, "R11 glitch starts no frame", data_ready, 0);
      @(negedge clk);

      // R10 error set wins over a status read held throughout the frame
      par_sel = 2'b11;
      seen_par = 0;
      busy = 1;
      rd_addr = 1'b0;
      rd_en = 1'b1;
      send_frame(8'h0F, 1, 1, 1);
      rd_en = 1'b0;
      m_ovr = 0; m_frm = 0; m_par = 0;
      @(negedge clk);
      busy = 0;
      check(seen_par == 1, "R10 parity flag seen during read", seen_par, 1);
      read_reg(1'b0, 8'h00, "R10 flag cleared after read released");
      read_reg(1'b1, 8'h0F, "R10 buffer");

      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule